// File: doc/BRIEF.md
# Radio Control-Port SPI Transaction Sequencer

This block sits between a host and the serial control port of a radio transceiver. It acts as the SPI master. The host hands over one request at a time. Each request is a command strobe, a 16-bit register write, a 16-bit register read, or a burst access to the radio's on-chip RAM at a 9-bit address. For each request the block:

- pulls chip select low,
- builds the header bytes for that transaction type,
- shifts every byte MSB first in SPI mode 0,
- raises chip select,
- pulses `done_o` and presents the captured status byte and, for a register read, the 16-bit result.

RAM burst data moves over two byte streams with valid/ready handshakes. The write stream runs from the host into the block and the read stream runs from the block to the host. Either side may stall a burst at any byte. Chip select stays low during such a stall. The bit shifter runs at a fixed divider of the system clock (`CLK_DIV` system cycles per SPI half period).

Top module: `radio_spi_seq`

## Requirements
- R1: With `req_op_i` = 0 (command strobe), exactly one byte equal to `req_addr_i[7:0]` is sent in one chip-select window. `resp_status_o` is the byte received during it, unmodified.
- R2: With `req_op_i` = 1 (register write), the block sends three bytes in one chip-select window: `{2'b00, addr[5:0]}`, then `wdata[15:8]`, then `wdata[7:0]`. `resp_status_o` is the first received byte with bits 7 and 0 forced to 0.
- R3: With `req_op_i` = 2 (register read), the block sends `{2'b01, addr[5:0]}` followed by two 0x00 bytes. `resp_rdata_o` is the second received byte in bits 15:8 and the third in bits 7:0. `resp_status_o` is the first received byte, unmodified.
- R4: A RAM access (`req_op_i` = 3 for write, 4 for read) starts with header byte `{1'b1, addr[6:0]}`. The second header byte is `{addr[8:7], rd, 5'b00000}`, where `rd` is 1 for a read and 0 for a write. `resp_status_o` is the first received byte, unmodified.
- R5: A RAM write then sends exactly `req_len_i` data bytes, taken in order from the write stream. Exactly `req_len_i` write-stream handshakes occur, and a stalled stream holds the burst with chip select low.
- R6: A RAM read then sends exactly `req_len_i` 0x00 bytes. Each received byte is delivered in order on the read stream. While `rd_valid_o` is high and `rd_ready_i` is low, the byte is held and the burst waits.
- R7: The SPI bus runs in mode 0. `spi_sclk_o` is low whenever no byte is being shifted. `spi_mosi_o` changes only while `spi_sclk_o` is low. Bits go MSB first.
- R8: Each request produces exactly one chip-select window. After chip select rises, it stays high for at least `4*CLK_DIV` system cycles (two SPI clock periods) before it falls again.
- R9: `done_o` is a one-cycle pulse in the cycle after chip select rises. `resp_status_o` and `resp_rdata_o` are valid while it is high.
- R10: `req_ready_o` is low from acceptance until the post-transaction chip-select gap ends. A `req_valid_i` raised during that time is not taken and sends no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_op_i | input | 3 | Transaction type: 0 strobe, 1 reg write, 2 reg read, 3 RAM write, 4 RAM read |
| req_addr_i | input | 9 | Strobe byte, register address (bits 5:0) or RAM address |
| req_len_i | input | 8 | RAM burst length in bytes (1 to 255) |
| req_wdata_i | input | 16 | Register write data |
| wr_valid_i | input | 1 | RAM write byte offered |
| wr_ready_o | output | 1 | RAM write byte taken when high together with valid |
| wr_data_i | input | 8 | RAM write byte |
| rd_valid_o | output | 1 | RAM read byte available |
| rd_ready_i | input | 1 | Host takes RAM read byte |
| rd_data_o | output | 8 | RAM read byte |
| done_o | output | 1 | One-cycle transaction completion pulse |
| resp_status_o | output | 8 | Status byte captured from the first byte |
| resp_rdata_o | output | 16 | Register read result |
| spi_csn_o | output | 1 | Chip select, active low |
| spi_sclk_o | output | 1 | SPI clock, idle low |
| spi_mosi_o | output | 1 | Serial data to the radio |
| spi_miso_i | input | 1 | Serial data from the radio |

## Verification
The hardest state to reach from the ports is a RAM burst paused in mid-flight with chip select held low. This happens either when the write stream has no byte to offer or when the host refuses a read byte. The stimulus gets there by withholding write bytes and deasserting `rd_ready_i` on fixed cycle patterns that fall between SPI bytes. A bus-level radio model checks that each window still holds exactly the expected byte count and that no byte is repeated or lost. A request is also raised during a long burst to show that it is ignored.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 9;
    localparam int LEN_W   = 8;
    localparam int WORD_W  = 16;
    localparam int IDX_W   = LEN_W + 1;

    typedef enum logic [2:0] {
        OP_STROBE = 3'd0,
        OP_REG_WR = 3'd1,
        OP_REG_RD = 3'd2,
        OP_RAM_WR = 3'd3,
        OP_RAM_RD = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_WR_WAIT,
        S_SHIFT,
        S_RD_PUSH,
        S_GAP
    } st_e;

endpackage

// File: rtl/rsq_shift.sv
module rsq_shift
    import rsq_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] tx_i,
    input  logic              miso_i,
    output logic              done_o,
    output logic [BYTE_W-1:0] rx_o,
    output logic              sclk_o,
    output logic              mosi_o
);

    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

    typedef struct packed {
        logic              active;
        logic              sclk;
        logic [DIV_W-1:0]  div;
        logic [BIT_W-1:0]  bitn;
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] rx;
        logic              done;
    } sh_t;

    sh_t sh_q, sh_d;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (!sh_q.active) begin
            if (start_i) begin
                sh_d.active = 1'b1;
                sh_d.sclk   = 1'b0;
                sh_d.div    = '0;
                sh_d.bitn   = '0;
                sh_d.tx     = tx_i;
            end
        end else if (sh_q.div == DIV_LAST) begin
            sh_d.div = '0;
            if (!sh_q.sclk) begin
                sh_d.sclk = 1'b1;
                sh_d.rx   = {sh_q.rx[BYTE_W-2:0], miso_i};
            end else begin
                sh_d.sclk = 1'b0;
                if (sh_q.bitn == BIT_LAST) begin
                    sh_d.active = 1'b0;
                    sh_d.done   = 1'b1;
                end else begin
                    sh_d.bitn = sh_q.bitn + BIT_W'(1);
                    sh_d.tx   = {sh_q.tx[BYTE_W-2:0], 1'b0};
                end
            end
        end else begin
            sh_d.div = sh_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign done_o = sh_q.done;
    assign rx_o   = sh_q.rx;
    assign sclk_o = sh_q.sclk;
    assign mosi_o = sh_q.tx[BYTE_W-1];

    // R7: clock rests low outside a byte
    p_sclk_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_q.active |-> !sh_q.sclk);

    // R7: data line holds while the clock is high
    p_mosi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.sclk && $past(sh_q.sclk)) |-> $stable(mosi_o));

endmodule

// File: rtl/rsq_hdr.sv
module rsq_hdr
    import rsq_pkg::*;
(
    input  op_e               op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [BYTE_W-1:0] wbyte_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [BYTE_W-1:0] tx_o,
    output logic [IDX_W-1:0]  total_o,
    output logic              need_wr_o,
    output logic              rd_data_o
);

    localparam logic [IDX_W-1:0] HDR_RAM = IDX_W'(2);

    logic ram_rd;
    logic in_body;

    assign ram_rd  = (op_i == OP_RAM_RD);
    assign in_body = (idx_i >= HDR_RAM);

    always_comb begin
        tx_o      = '0;
        total_o   = IDX_W'(1);
        need_wr_o = 1'b0;
        rd_data_o = 1'b0;
        unique case (op_i)
            OP_REG_WR: begin
                total_o = IDX_W'(3);
                if (idx_i == '0)                tx_o = {2'b00, addr_i[5:0]};
                else if (idx_i == IDX_W'(1))    tx_o = wdata_i[WORD_W-1:BYTE_W];
                else                            tx_o = wdata_i[BYTE_W-1:0];
            end
            OP_REG_RD: begin
                total_o = IDX_W'(3);
                if (idx_i == '0)                tx_o = {2'b01, addr_i[5:0]};
                else                            tx_o = '0;
            end
            OP_RAM_WR, OP_RAM_RD: begin
                total_o = HDR_RAM + IDX_W'(len_i);
                if (idx_i == '0)                tx_o = {1'b1, addr_i[6:0]};
                else if (idx_i == IDX_W'(1))    tx_o = {addr_i[8:7], ram_rd, 5'b00000};
                else if (ram_rd)                tx_o = '0;
                else                            tx_o = wbyte_i;
                need_wr_o = in_body && !ram_rd;
                rd_data_o = in_body && ram_rd;
            end
            default: begin
                total_o = IDX_W'(1);
                tx_o    = addr_i[BYTE_W-1:0];
            end
        endcase
    end

endmodule

// File: rtl/rsq_ctrl.sv
module rsq_ctrl
    import rsq_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  op_e               req_op_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [LEN_W-1:0]  req_len_i,
    input  logic [WORD_W-1:0] req_wdata_i,
    input  logic              wr_valid_i,
    output logic              wr_ready_o,
    output logic              rd_valid_o,
    input  logic              rd_ready_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              done_o,
    output logic [BYTE_W-1:0] status_o,
    output logic [WORD_W-1:0] rdata_o,
    output logic              csn_o,
    output op_e               op_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [WORD_W-1:0] wdata_o,
    output logic [IDX_W-1:0]  idx_o,
    input  logic [IDX_W-1:0]  total_i,
    input  logic              need_wr_i,
    input  logic              rd_data_i,
    output logic              start_o,
    input  logic              sh_done_i,
    input  logic [BYTE_W-1:0] sh_rx_i
);

    localparam int GAP_CYC = 4 * CLK_DIV;
    localparam int GAP_W   = $clog2(GAP_CYC + 1);
    localparam logic [GAP_W-1:0]  GAP_LAST = GAP_W'(GAP_CYC - 1);
    localparam logic [BYTE_W-1:0] RSV_MASK = 8'h7E;

    typedef struct packed {
        st_e               st;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [WORD_W-1:0] wdata;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] status;
        logic [WORD_W-1:0] rdata;
        logic              csn;
        logic              done;
        logic              rdv;
        logic [BYTE_W-1:0] rdd;
        logic [GAP_W-1:0]  gap;
    } ctl_t;

    ctl_t c_q, c_d;
    logic adv;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        start_o  = 1'b0;
        adv      = 1'b0;
        unique case (c_q.st)
            S_IDLE: begin
                if (req_valid_i) begin
                    c_d.op     = req_op_i;
                    c_d.addr   = req_addr_i;
                    c_d.len    = req_len_i;
                    c_d.wdata  = req_wdata_i;
                    c_d.idx    = '0;
                    c_d.status = '0;
                    c_d.rdata  = '0;
                    c_d.csn    = 1'b0;
                    c_d.st     = S_LOAD;
                end
            end
            S_LOAD: begin
                if (need_wr_i) begin
                    c_d.st = S_WR_WAIT;
                end else begin
                    start_o = 1'b1;
                    c_d.st  = S_SHIFT;
                end
            end
            S_WR_WAIT: begin
                if (wr_valid_i) begin
                    start_o = 1'b1;
                    c_d.st  = S_SHIFT;
                end
            end
            S_SHIFT: begin
                if (sh_done_i) begin
                    if (c_q.idx == '0) begin
                        c_d.status = (c_q.op == OP_REG_WR) ? (sh_rx_i & RSV_MASK) : sh_rx_i;
                    end
                    if (c_q.op == OP_REG_RD) begin
                        if (c_q.idx == IDX_W'(1)) c_d.rdata[WORD_W-1:BYTE_W] = sh_rx_i;
                        if (c_q.idx == IDX_W'(2)) c_d.rdata[BYTE_W-1:0]      = sh_rx_i;
                    end
                    if (rd_data_i) begin
                        c_d.rdv = 1'b1;
                        c_d.rdd = sh_rx_i;
                        c_d.st  = S_RD_PUSH;
                    end else begin
                        adv = 1'b1;
                    end
                end
            end
            S_RD_PUSH: begin
                if (rd_ready_i) begin
                    c_d.rdv = 1'b0;
                    adv     = 1'b1;
                end
            end
            S_GAP: begin
                c_d.gap = c_q.gap + GAP_W'(1);
                if (c_q.gap == '0) c_d.done = 1'b1;
                if (c_q.gap == GAP_LAST) begin
                    c_d.gap = '0;
                    c_d.st  = S_IDLE;
                end
            end
            default: c_d.st = S_IDLE;
        endcase

        if (adv) begin
            if ((c_q.idx + IDX_W'(1)) == total_i) begin
                c_d.csn = 1'b1;
                c_d.gap = '0;
                c_d.st  = S_GAP;
            end else begin
                c_d.idx = c_q.idx + IDX_W'(1);
                c_d.st  = S_LOAD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q     <= '0;
            c_q.st  <= S_IDLE;
            c_q.op  <= OP_STROBE;
            c_q.csn <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign req_ready_o = (c_q.st == S_IDLE);
    assign wr_ready_o  = (c_q.st == S_WR_WAIT);
    assign rd_valid_o  = c_q.rdv;
    assign rd_data_o   = c_q.rdd;
    assign done_o      = c_q.done;
    assign status_o    = c_q.status;
    assign rdata_o     = c_q.rdata;
    assign csn_o       = c_q.csn;
    assign op_o        = c_q.op;
    assign addr_o      = c_q.addr;
    assign len_o       = c_q.len;
    assign wdata_o     = c_q.wdata;
    assign idx_o       = c_q.idx;

    // Cycles chip select has been high, saturating; used by the gap check below.
    logic [GAP_W-1:0] hi_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        hi_cnt_q <= GAP_W'(GAP_CYC);
        else if (!c_q.csn)                 hi_cnt_q <= '0;
        else if (hi_cnt_q != GAP_W'(GAP_CYC)) hi_cnt_q <= hi_cnt_q + GAP_W'(1);
    end

    p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(c_q.csn) |-> (hi_cnt_q >= GAP_W'(GAP_CYC)));

    p_done_after_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.csn) |=> c_q.done);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.done |=> !c_q.done);

    p_cs_only_on_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(c_q.csn) |-> $past(req_valid_i && req_ready_o));

    p_wr_inside_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready_o |-> !c_q.csn);

    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));

endmodule

// File: rtl/radio_spi_seq.sv
module radio_spi_seq
    import rsq_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid_i,
    output logic        req_ready_o,
    input  logic [2:0]  req_op_i,
    input  logic [8:0]  req_addr_i,
    input  logic [7:0]  req_len_i,
    input  logic [15:0] req_wdata_i,
    input  logic        wr_valid_i,
    output logic        wr_ready_o,
    input  logic [7:0]  wr_data_i,
    output logic        rd_valid_o,
    input  logic        rd_ready_i,
    output logic [7:0]  rd_data_o,
    output logic        done_o,
    output logic [7:0]  resp_status_o,
    output logic [15:0] resp_rdata_o,
    output logic        spi_csn_o,
    output logic        spi_sclk_o,
    output logic        spi_mosi_o,
    input  logic        spi_miso_i
);

    op_e               cur_op;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  cur_len;
    logic [WORD_W-1:0] cur_wdata;
    logic [IDX_W-1:0]  cur_idx;
    logic [IDX_W-1:0]  total;
    logic              need_wr;
    logic              rd_byte;
    logic [BYTE_W-1:0] tx_byte;
    logic              sh_start;
    logic              sh_done;
    logic [BYTE_W-1:0] sh_rx;

    rsq_ctrl #(.CLK_DIV(CLK_DIV)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_ready_o (req_ready_o),
        .req_op_i    (op_e'(req_op_i)),
        .req_addr_i  (req_addr_i),
        .req_len_i   (req_len_i),
        .req_wdata_i (req_wdata_i),
        .wr_valid_i  (wr_valid_i),
        .wr_ready_o  (wr_ready_o),
        .rd_valid_o  (rd_valid_o),
        .rd_ready_i  (rd_ready_i),
        .rd_data_o   (rd_data_o),
        .done_o      (done_o),
        .status_o    (resp_status_o),
        .rdata_o     (resp_rdata_o),
        .csn_o       (spi_csn_o),
        .op_o        (cur_op),
        .addr_o      (cur_addr),
        .len_o       (cur_len),
        .wdata_o     (cur_wdata),
        .idx_o       (cur_idx),
        .total_i     (total),
        .need_wr_i   (need_wr),
        .rd_data_i   (rd_byte),
        .start_o     (sh_start),
        .sh_done_i   (sh_done),
        .sh_rx_i     (sh_rx)
    );

    rsq_hdr u_hdr (
        .op_i      (cur_op),
        .addr_i    (cur_addr),
        .len_i     (cur_len),
        .wdata_i   (cur_wdata),
        .wbyte_i   (wr_data_i),
        .idx_i     (cur_idx),
        .tx_o      (tx_byte),
        .total_o   (total),
        .need_wr_o (need_wr),
        .rd_data_o (rd_byte)
    );

    rsq_shift #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (sh_start),
        .tx_i    (tx_byte),
        .miso_i  (spi_miso_i),
        .done_o  (sh_done),
        .rx_o    (sh_rx),
        .sclk_o  (spi_sclk_o),
        .mosi_o  (spi_mosi_o)
    );

endmodule

// File: tb/radio_spi_seq_test.sv
`timescale 1ns/1ps
module radio_spi_seq_test;

    localparam int CLK_DIV = 2;
    localparam int GAP_MIN = 4 * CLK_DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [2:0]  req_op_i = '0;
    logic [8:0]  req_addr_i = '0;
    logic [7:0]  req_len_i = '0;
    logic [15:0] req_wdata_i = '0;
    logic        wr_valid_i = 1'b0;
    logic        wr_ready_o;
    logic [7:0]  wr_data_i = '0;
    logic        rd_valid_o;
    logic        rd_ready_i = 1'b0;
    logic [7:0]  rd_data_o;
    logic        done_o;
    logic [7:0]  resp_status_o;
    logic [15:0] resp_rdata_o;
    logic        spi_csn_o;
    logic        spi_sclk_o;
    logic        spi_mosi_o;
    logic        spi_miso_i = 1'b0;

    always #10 clk = ~clk;

    radio_spi_seq #(.CLK_DIV(CLK_DIV)) uut (.*);

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit started = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] resp(input int t, input int k);
        return 8'hC3 ^ 8'(t * 29) ^ 8'(k * 71);
    endfunction

    // Scoreboard queues
    logic [7:0] exp_mosi[$];
    int         exp_win[$];
    logic [7:0] exp_st[$];
    logic [15:0] exp_rdat[$];
    bit         exp_isrd[$];
    logic [7:0] exp_rd[$];
    logic [7:0] wr_src[$];
    int wr_ptr = 0;
    int issued = 0;
    int done_cnt = 0;

    // Radio model on the SPI bus
    int s_txn = 0, s_bit = 0, s_k = 0, win_bytes = 0;
    logic [7:0] s_out = '0, s_in = '0;

    always @(negedge spi_csn_o) if (started) begin
        s_bit = 0; s_k = 0; win_bytes = 0;
        s_out = resp(s_txn, 0);
        spi_miso_i = s_out[7];
    end

    always @(posedge spi_sclk_o) if (started && !spi_csn_o) begin
        s_in = {s_in[6:0], spi_mosi_o};
        s_bit++;
        if (s_bit == 8) begin
            s_bit = 0; s_k++; win_bytes++;
            if (exp_mosi.size() == 0) chk("R10 unexpected MOSI byte", {24'h0, s_in}, 32'hFFFF_FFFF);
            else chk("R1-4 MOSI byte (R1 R2 R3 R4 R5 R6)", {24'h0, s_in}, {24'h0, exp_mosi.pop_front()});
        end
    end

    always @(negedge spi_sclk_o) if (started && !spi_csn_o) begin
        if (s_bit == 0) begin
            s_out = resp(s_txn, s_k);
            spi_miso_i = s_out[7];
        end else begin
            spi_miso_i = s_out[7 - s_bit];
        end
    end

    always @(posedge spi_csn_o) if (started) begin
        chk("R7 sclk low at CS rise", {31'h0, spi_sclk_o}, 32'h0);
        if (exp_win.size() == 0) chk("R8 unexpected CS window", 32'(win_bytes), 32'hFFFF_FFFF);
        else chk("R8 bytes in CS window", 32'(win_bytes), 32'(exp_win.pop_front()));
        s_txn++;
    end

    // Monitor / stream models, all at the falling clock edge
    bit wr_pend = 0;
    bit csn_h1 = 1, csn_h2 = 1, had_txn = 0;
    int hi_run = 0;

    always @(negedge clk) begin
        cyc++;
        if (started) begin
            // write stream producer (R5)
            if (wr_pend) wr_ptr++;
            if (wr_ptr < wr_src.size() && (cyc % 3 != 1)) begin
                wr_valid_i = 1'b1;
                wr_data_i  = wr_src[wr_ptr];
            end else begin
                wr_valid_i = 1'b0;
            end
            wr_pend = wr_valid_i && wr_ready_o;

            // read stream consumer with backpressure (R6)
            rd_ready_i = (cyc % 4 != 2) && (cyc % 7 != 3);
            if (rd_valid_o && rd_ready_i) begin
                if (exp_rd.size() == 0) chk("R6 unexpected read byte", {24'h0, rd_data_o}, 32'hFFFF_FFFF);
                else chk("R6 read stream byte", {24'h0, rd_data_o}, {24'h0, exp_rd.pop_front()});
            end

            // done pulse and results (R9, R1, R2, R3, R4)
            if (done_o) begin
                done_cnt++;
                chk("R9 done one cycle after CS rise",
                    {29'h0, spi_csn_o, csn_h1, !csn_h2}, 32'h7);
                if (exp_st.size() == 0) begin
                    chk("R9 unexpected done", 32'h0, 32'h1);
                end else begin
                    chk("R1 R2 R3 R4 status byte", {24'h0, resp_status_o}, {24'h0, exp_st.pop_front()});
                    if (exp_isrd.pop_front())
                        chk("R3 read data", {16'h0, resp_rdata_o}, {16'h0, exp_rdat.pop_front()});
                    else
                        void'(exp_rdat.pop_front());
                end
            end

            // chip-select gap (R8)
            if (spi_csn_o) begin
                hi_run++;
            end else begin
                if (csn_h1 && had_txn) chk("R8 CS high gap", 32'(hi_run >= GAP_MIN), 32'h1);
                hi_run = 0;
            end
            if (spi_csn_o && !csn_h1) had_txn = 1;
            csn_h2 = csn_h1;
            csn_h1 = spi_csn_o;
        end
    end

    // Driver: computes expected items from the requirements and issues a request.
    task automatic issue(input logic [2:0] op, input logic [8:0] addr,
                         input int len, input logic [15:0] wd, input bit intrude);
        int t = issued;
        int nb;
        logic [7:0] st;
        logic [15:0] rdat = '0;
        issued++;
        st = resp(t, 0);
        case (op)
            3'd1: begin
                exp_mosi.push_back({2'b00, addr[5:0]});
                exp_mosi.push_back(wd[15:8]);
                exp_mosi.push_back(wd[7:0]);
                nb = 3;
                st = st & 8'h7E;
            end
            3'd2: begin
                exp_mosi.push_back({2'b01, addr[5:0]});
                exp_mosi.push_back(8'h00);
                exp_mosi.push_back(8'h00);
                nb = 3;
                rdat = {resp(t, 1), resp(t, 2)};
            end
            3'd3, 3'd4: begin
                exp_mosi.push_back({1'b1, addr[6:0]});
                exp_mosi.push_back({addr[8:7], (op == 3'd4), 5'b00000});
                for (int i = 0; i < len; i++) begin
                    if (op == 3'd4) begin
                        exp_mosi.push_back(8'h00);
                        exp_rd.push_back(resp(t, 2 + i));
                    end else begin
                        logic [7:0] b = 8'(i * 13 + t * 7 + 1);
                        exp_mosi.push_back(b);
                        wr_src.push_back(b);
                    end
                end
                nb = 2 + len;
            end
            default: begin
                exp_mosi.push_back(addr[7:0]);
                nb = 1;
            end
        endcase
        exp_win.push_back(nb);
        exp_st.push_back(st);
        exp_rdat.push_back(rdat);
        exp_isrd.push_back(op == 3'd2);

        @(negedge clk);
        while (!req_ready_o) @(negedge clk);
        req_op_i    = op;
        req_addr_i  = addr;
        req_len_i   = 8'(len);
        req_wdata_i = wd;
        req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        if (intrude) begin
            // R10: a request offered mid-transaction must not be taken
            req_op_i   = 3'd0;
            req_addr_i = 9'h0FF;
            for (int i = 0; i < 4; i++) begin
                req_valid_i = 1'b1;
                chk("R10 ready low while busy", {31'h0, req_ready_o}, 32'h0);
                @(negedge clk);
            end
            req_valid_i = 1'b0;
        end
    endtask

    task automatic wait_all;
        while (done_cnt < issued) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk("watchdog expired", 32'h0, 32'h1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk("R8 CS high after reset", {31'h0, spi_csn_o}, 32'h1);
        chk("R7 sclk low after reset", {31'h0, spi_sclk_o}, 32'h0);
        chk("R10 ready after reset", {31'h0, req_ready_o}, 32'h1);
        chk("R9 no done after reset", {31'h0, done_o}, 32'h0);
        chk("R6 no read byte after reset", {31'h0, rd_valid_o}, 32'h0);
        chk("R5 no write ready after reset", {31'h0, wr_ready_o}, 32'h0);
        started = 1;

        issue(3'd1, 9'h015, 0, 16'hBEEF, 0);  wait_all();   // R2 masked status
        issue(3'd0, 9'h10E, 0, 16'h0, 0);     wait_all();   // R1
        issue(3'd2, 9'h02A, 0, 16'h0, 0);     wait_all();   // R3
        issue(3'd3, 9'h1A5, 5, 16'h0, 1);     wait_all();   // R4 R5 R10
        issue(3'd4, 9'h0C3, 6, 16'h0, 0);     wait_all();   // R4 R6
        issue(3'd3, 9'h080, 1, 16'h0, 0);     wait_all();   // R5 single byte
        issue(3'd4, 9'h17F, 1, 16'h0, 0);     wait_all();   // R6 single byte
        issue(3'd1, 9'h1FF, 0, 16'h0001, 0);  wait_all();   // R2 address masking
        // Back-to-back requests: gap between windows (R8)
        issue(3'd0, 9'h003, 0, 16'h0, 0);
        issue(3'd2, 9'h111, 0, 16'h0, 0);
        issue(3'd4, 9'h105, 3, 16'h0, 1);
        wait_all();
        repeat (20) @(negedge clk);

        chk("R1-R6 all MOSI bytes seen (R5 R6)", 32'(exp_mosi.size()), 32'h0);
        chk("R5 write stream fully consumed", 32'(wr_ptr), 32'(wr_src.size()));
        chk("R6 read stream fully delivered", 32'(exp_rd.size()), 32'h0);
        chk("R8 one window per request", 32'(s_txn), 32'(issued));
        chk("R9 one done per request", 32'(done_cnt), 32'(issued));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule